// File: doc/BRIEF.md
# SCSI Target Phase Sequencer

This block sits on the target side of a parallel SCSI bus. It moves the bus from one information-transfer phase to the next. A request carries a 4-bit phase code. When the code differs from the current phase, the sequencer first waits until the initiator has released ACK. It then drives the three phase lines (message, control/data, direction) from the code and enables the control output drivers. After that it keeps `busy` high for a settle window and ends with a one-clock `done` pulse. Byte handshaking is handled elsewhere; this block only owns the phase lines and their enable.

The settle window is counted in clock cycles. It is a base interval, plus an extra term when the direction line changes, plus a large term when a compatibility flag for legacy single-ended hosts is set. With that flag set, a change into either data phase also waits a long pre-delay before the lines move. A code with its top bit set, or a separate bus-free request, releases every output at once and completes without any settle time. A request for the phase that is already current completes at once and changes nothing. A request is accepted only while the block is idle.

Top module: `scsi_phase_seq`

## Requirements
- R1: After reset, `ctl_oe`, `msg_o`, `cd_o`, `io_o`, `busy` and `done` are low and `cur_phase` is 4'hF (the bus-free code).
- R2: An accepted request whose code equals `cur_phase` gives `done` on the next cycle, never raises `busy` and changes no output.
- R3: For a phase change, while `ack_in` is high (and `bus_reset` low), the sequencer stays waiting and the phase lines and `ctl_oe` hold their values.
- R4: When `bus_reset` is high, the wait for ACK ends even though `ack_in` is still high.
- R5: When a non-negative code is applied, `msg_o` = bit 2, `cd_o` = bit 1, `io_o` = bit 0, `ctl_oe` goes high and `cur_phase` takes the code. Codes: DATA OUT 4'h0, DATA IN 4'h1, COMMAND 4'h2, STATUS 4'h3, MSG OUT 4'h6, MSG IN 4'h7.
- R6: With `ack_in` low at acceptance, `done` rises BASE_CYC+1 cycles after the accepting edge when the direction bit is unchanged and the compatibility flag is clear.
- R7: When bit 0 of the new code differs from bit 0 of `cur_phase` (bus-free 4'hF counts as 1), FLIP_CYC cycles are added to the settle window.
- R8: With `compat_mode` high when the lines are applied, COMPAT_CYC cycles are added to the settle window of every phase change.
- R9: With `compat_mode` high, a change into DATA OUT or DATA IN waits PRE_CYC extra cycles after ACK is released, before the lines are driven.
- R10: A request whose code has bit 3 set releases all outputs on the next cycle, stores the code in `cur_phase`, and gives `done` on the same cycle without `busy`.
- R11: `bus_free_req` (which wins over `req_valid`) releases all outputs, sets `cur_phase` to 4'hF and gives `done` on the next cycle.
- R12: `busy` is high from the accepting edge until the cycle in which `done` pulses for one clock. Requests seen while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Phase request strobe, sampled while idle |
| req_phase | input | 4 | Requested phase code; bit 3 set means release |
| bus_free_req | input | 1 | Go to bus free and release all outputs |
| ack_in | input | 1 | Initiator ACK, active high |
| bus_reset | input | 1 | Bus reset flag; ends the ACK wait |
| compat_mode | input | 1 | Legacy host compatibility: longer delays |
| msg_o | output | 1 | Message line drive |
| cd_o | output | 1 | Control/data line drive |
| io_o | output | 1 | Direction line drive |
| ctl_oe | output | 1 | Control output driver enable |
| cur_phase | output | 4 | Current phase code |
| busy | output | 1 | Phase change in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Immediate completions (same phase, negative code, bus free) show `done` one cycle after the accepting edge. A phase change with ACK already low moves the lines one cycle after that edge and gives `done` after the settle window plus one. Each cycle that ACK stays high adds one cycle to both, and the compatibility pre-delay adds PRE_CYC before the lines move. The driver task records the cycle number at which each request is presented and queues the latency worked out from these rules. The monitor samples on the falling edge, measures the latency at each `done` pulse and compares the phase lines there. Intermediate checks in the middle of the ACK wait and of the pre-delay confirm that the lines have not moved early.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

  localparam int PH_W = 4;

  localparam logic [PH_W-1:0] PH_BUS_FREE = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_PRE    = 2'd2,
    ST_SETTLE = 2'd3
  } seq_state_e;

  // data phases: non-negative code with message and control bits both clear
  function automatic logic is_data_phase(input logic [PH_W-1:0] code);
    return (code[PH_W-1] == 1'b0) && (code[2:1] == 2'b00);
  endfunction

endpackage

// File: rtl/scsi_settle_calc.sv
module scsi_settle_calc #(
  parameter int BASE_CYC   = 40,
  parameter int FLIP_CYC   = 40,
  parameter int COMPAT_CYC = 10000,
  parameter int CNT_W      = 16
) (
  input  logic             old_io,
  input  logic             new_io,
  input  logic             compat,
  output logic [CNT_W-1:0] settle
);

  logic [CNT_W-1:0] flip_term;
  logic [CNT_W-1:0] compat_term;

  always_comb begin
    flip_term   = (old_io != new_io) ? CNT_W'(FLIP_CYC) : '0;
    compat_term = compat ? CNT_W'(COMPAT_CYC) : '0;
    settle      = CNT_W'(BASE_CYC) + flip_term + compat_term;
  end

endmodule

// File: rtl/scsi_delay_timer.sv
module scsi_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_nx = load_val;
    end else begin
      cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nx;
    end
  end

  assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/scsi_phase_drv.sv
module scsi_phase_drv
  import scsi_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drive,
  input  logic [PH_W-1:0] drive_phase,
  input  logic            release_now,
  input  logic [PH_W-1:0] release_phase,
  output logic            msg_o,
  output logic            cd_o,
  output logic            io_o,
  output logic            oe_o,
  output logic [PH_W-1:0] cur_o
);

  logic [2:0]      lines_q, lines_nx;
  logic            oe_q, oe_nx;
  logic [PH_W-1:0] cur_q, cur_nx;
  logic            upd_en;

  always_comb begin
    upd_en   = drive || release_now;
    lines_nx = '0;
    oe_nx    = 1'b0;
    cur_nx   = release_phase;
    if (drive) begin
      lines_nx = drive_phase[2:0];
      oe_nx    = 1'b1;
      cur_nx   = drive_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      oe_q    <= 1'b0;
      cur_q   <= PH_BUS_FREE;
    end else if (upd_en) begin
      lines_q <= lines_nx;
      oe_q    <= oe_nx;
      cur_q   <= cur_nx;
    end
  end

  assign msg_o = lines_q[2];
  assign cd_o  = lines_q[1];
  assign io_o  = lines_q[0];
  assign oe_o  = oe_q;
  assign cur_o = cur_q;

endmodule

// File: rtl/scsi_phase_seq.sv
module scsi_phase_seq
  import scsi_seq_pkg::*;
#(
  parameter int BASE_CYC   = 40,
  parameter int FLIP_CYC   = 40,
  parameter int COMPAT_CYC = 10000,
  parameter int PRE_CYC    = 40000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [PH_W-1:0] req_phase,
  input  logic            bus_free_req,
  input  logic            ack_in,
  input  logic            bus_reset,
  input  logic            compat_mode,
  output logic            msg_o,
  output logic            cd_o,
  output logic            io_o,
  output logic            ctl_oe,
  output logic [PH_W-1:0] cur_phase,
  output logic            busy,
  output logic            done
);

  localparam int SETTLE_MAX = BASE_CYC + FLIP_CYC + COMPAT_CYC;
  localparam int CNT_MAX    = (SETTLE_MAX > PRE_CYC) ? SETTLE_MAX : PRE_CYC;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_n_s = rst_pipe[1];

  seq_state_e       st, st_nx;
  logic [PH_W-1:0]  target_q, target_nx;
  logic             done_q, done_nx;
  logic             drive, rel;
  logic [PH_W-1:0]  rel_phase;
  logic             tmr_load, tmr_expire;
  logic [CNT_W-1:0] tmr_val, settle;

  scsi_settle_calc #(
    .BASE_CYC  (BASE_CYC),
    .FLIP_CYC  (FLIP_CYC),
    .COMPAT_CYC(COMPAT_CYC),
    .CNT_W     (CNT_W)
  ) u_calc (
    .old_io(cur_phase[0]),
    .new_io(target_q[0]),
    .compat(compat_mode),
    .settle(settle)
  );

  scsi_delay_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expire  (tmr_expire)
  );

  scsi_phase_drv u_drv (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .drive        (drive),
    .drive_phase  (target_q),
    .release_now  (rel),
    .release_phase(rel_phase),
    .msg_o        (msg_o),
    .cd_o         (cd_o),
    .io_o         (io_o),
    .oe_o         (ctl_oe),
    .cur_o        (cur_phase)
  );

  // next-state logic
  always_comb begin
    st_nx     = st;
    target_nx = target_q;
    done_nx   = 1'b0;
    drive     = 1'b0;
    rel       = 1'b0;
    rel_phase = PH_BUS_FREE;
    tmr_load  = 1'b0;
    tmr_val   = settle;
    unique case (st)
      ST_IDLE: begin
        if (bus_free_req) begin
          rel     = 1'b1;
          done_nx = 1'b1;
        end else if (req_valid) begin
          if (req_phase == cur_phase) begin
            done_nx = 1'b1;
          end else if (req_phase[PH_W-1]) begin
            rel       = 1'b1;
            rel_phase = req_phase;
            done_nx   = 1'b1;
          end else begin
            target_nx = req_phase;
            st_nx     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!ack_in || bus_reset) begin
          if (compat_mode && is_data_phase(target_q)) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PRE_CYC);
            st_nx    = ST_PRE;
          end else begin
            drive    = 1'b1;
            tmr_load = 1'b1;
            st_nx    = ST_SETTLE;
          end
        end
      end
      ST_PRE: begin
        if (tmr_expire) begin
          drive    = 1'b1;
          tmr_load = 1'b1;
          st_nx    = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_expire) begin
          done_nx = 1'b1;
          st_nx   = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st       <= ST_IDLE;
      target_q <= '0;
      done_q   <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= done_nx;
      if (st == ST_IDLE) begin
        target_q <= target_nx;
      end
    end
  end

  assign busy = (st != ST_IDLE);
  assign done = done_q;

endmodule

module scsi_phase_seq_chk
  import scsi_seq_pkg::*;
(
  input logic            clk,
  input logic            rst_n_s,
  input logic            req_valid,
  input logic [PH_W-1:0] req_phase,
  input logic            bus_free_req,
  input logic            ack_in,
  input logic            bus_reset,
  input logic            msg_o,
  input logic            cd_o,
  input logic            io_o,
  input logic            ctl_oe,
  input logic [PH_W-1:0] cur_phase,
  input logic            busy,
  input logic            done,
  input seq_state_e      st
);

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_WAIT && ack_in && !bus_reset) |=> $stable({msg_o, cd_o, io_o, ctl_oe}));

  // R2
  same_phase_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && req_valid && !bus_free_req && req_phase == cur_phase)
      |=> (done && !busy && $stable(cur_phase)));

  // R10
  neg_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && req_valid && !bus_free_req && req_phase[PH_W-1])
      |=> (done && !ctl_oe && cur_phase == $past(req_phase)));

  // R11
  bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && bus_free_req) |=> (done && !ctl_oe && cur_phase == PH_BUS_FREE));

  // R5
  drive_match_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(ctl_oe) |-> ({msg_o, cd_o, io_o} == cur_phase[2:0] && !cur_phase[PH_W-1]));

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !busy);

  // R12
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(busy) |-> done);

endmodule

bind scsi_phase_seq scsi_phase_seq_chk u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .req_valid   (req_valid),
  .req_phase   (req_phase),
  .bus_free_req(bus_free_req),
  .ack_in      (ack_in),
  .bus_reset   (bus_reset),
  .msg_o       (msg_o),
  .cd_o        (cd_o),
  .io_o        (io_o),
  .ctl_oe      (ctl_oe),
  .cur_phase   (cur_phase),
  .busy        (busy),
  .done        (done),
  .st          (st)
);

// File: tb/scsi_phase_seq_bench.sv
module scsi_phase_seq_bench;

  localparam int B = 8;
  localparam int F = 6;
  localparam int C = 50;
  localparam int P = 120;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_phase = 4'h0;
  logic       bus_free_req = 1'b0;
  logic       ack_in = 1'b0;
  logic       bus_reset = 1'b0;
  logic       compat_mode = 1'b0;
  logic       msg_o, cd_o, io_o, ctl_oe, busy, done;
  logic [3:0] cur_phase;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] ph;
    logic       oe;
    int         lat;
    int         c0;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  scsi_phase_seq #(
    .BASE_CYC  (B),
    .FLIP_CYC  (F),
    .COMPAT_CYC(C),
    .PRE_CYC   (P)
  ) u_scsi_phase_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_phase   (req_phase),
    .bus_free_req(bus_free_req),
    .ack_in      (ack_in),
    .bus_reset   (bus_reset),
    .compat_mode (compat_mode),
    .msg_o       (msg_o),
    .cd_o        (cd_o),
    .io_o        (io_o),
    .ctl_oe      (ctl_oe),
    .cur_phase   (cur_phase),
    .busy        (busy),
    .done        (done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: present one request for one cycle and queue its expected result
  task automatic issue(input logic [3:0] ph, input bit free, input int lat,
                       input logic [3:0] exp_cur, input logic exp_oe,
                       input string tag);
    exp_t e;
    @(negedge clk);
    req_valid    = !free;
    bus_free_req = free;
    req_phase    = ph;
    e.ph  = exp_cur;
    e.oe  = exp_oe;
    e.lat = lat;
    e.c0  = cyc;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid    = 1'b0;
    bus_free_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare each done pulse with the queued expectation
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R12", "unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        logic [2:0] exp_lines;
        e = q.pop_front();
        exp_lines = e.oe ? e.ph[2:0] : 3'b000;
        chk((cyc - e.c0 - 1) == e.lat, e.tag, "done latency", cyc - e.c0 - 1, e.lat);
        chk(cur_phase == e.ph, e.tag, "cur_phase", int'(cur_phase), int'(e.ph));
        chk(ctl_oe == e.oe, e.tag, "ctl_oe", int'(ctl_oe), int'(e.oe));
        chk({msg_o, cd_o, io_o} == exp_lines, e.tag, "phase lines",
            int'({msg_o, cd_o, io_o}), int'(exp_lines));
        chk(!busy, "R12", "busy at done", int'(busy), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ctl_oe && !busy && !done, "R1", "oe/busy/done in reset",
        int'({ctl_oe, busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cur_phase == 4'hF, "R1", "cur_phase after reset", int'(cur_phase), 15);
    chk({msg_o, cd_o, io_o} == 3'b000, "R1", "lines after reset",
        int'({msg_o, cd_o, io_o}), 0);

    // R5 R6: DATA IN from bus free, no direction flip
    issue(4'h1, 1'b0, B + 1, 4'h1, 1'b1, "R6");
    wait_idle();
    // R2: same phase completes at once
    issue(4'h1, 1'b0, 0, 4'h1, 1'b1, "R2");
    wait_idle();
    // R7: DATA OUT flips direction
    issue(4'h0, 1'b0, B + F + 1, 4'h0, 1'b1, "R7");
    wait_idle();
    // R5: COMMAND, no flip
    issue(4'h2, 1'b0, B + 1, 4'h2, 1'b1, "R5");
    wait_idle();

    // R3: ACK held high for four extra edges
    ack_in = 1'b1;
    issue(4'h3, 1'b0, B + F + 1 + 4, 4'h3, 1'b1, "R3");
    repeat (4) @(negedge clk);
    chk({msg_o, cd_o, io_o} == 3'b010, "R3", "lines held during ACK",
        int'({msg_o, cd_o, io_o}), 2);
    chk(busy, "R3", "busy during ACK wait", int'(busy), 1);
    ack_in = 1'b0;
    wait_idle();

    // R4: bus reset ends the wait although ACK stays high
    ack_in    = 1'b1;
    bus_reset = 1'b1;
    issue(4'h7, 1'b0, B + 1, 4'h7, 1'b1, "R4");
    wait_idle();
    ack_in    = 1'b0;
    bus_reset = 1'b0;

    // R8: compatibility settle term, with flip
    compat_mode = 1'b1;
    issue(4'h6, 1'b0, B + F + C + 1, 4'h6, 1'b1, "R8");
    wait_idle();
    // R9: compatibility pre-delay into DATA IN
    issue(4'h1, 1'b0, P + B + F + C + 1, 4'h1, 1'b1, "R9");
    repeat (100) @(negedge clk);
    chk({msg_o, cd_o, io_o} == 3'b110, "R9", "lines before pre-delay ends",
        int'({msg_o, cd_o, io_o}), 6);
    wait_idle();
    compat_mode = 1'b0;

    // R10: negative code releases at once
    issue(4'h8, 1'b0, 0, 4'h8, 1'b0, "R10");
    wait_idle();
    // R7: from released code 8 (bit 0 clear) into DATA IN flips
    issue(4'h1, 1'b0, B + F + 1, 4'h1, 1'b1, "R7");
    wait_idle();

    // R11: bus free, with a simultaneous request that must lose
    @(negedge clk);
    req_phase    = 4'h2;
    req_valid    = 1'b1;
    bus_free_req = 1'b1;
    begin
      exp_t e;
      e.ph = 4'hF; e.oe = 1'b0; e.lat = 0; e.c0 = cyc; e.tag = "R11";
      q.push_back(e);
    end
    @(negedge clk);
    req_valid    = 1'b0;
    bus_free_req = 1'b0;
    wait_idle();

    // R12: request during busy is ignored
    issue(4'h2, 1'b0, B + F + 1, 4'h2, 1'b1, "R12");
    req_phase = 4'h3;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (B + F + 4) @(negedge clk);
    chk(cur_phase == 4'h2, "R12", "phase after ignored request", int'(cur_phase), 2);
    chk(!busy && !done, "R12", "idle after ignored request", int'({busy, done}), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule